// File: doc/BRIEF.md
# Line Sensor Readout Sequencer

This block is the digital sequencer of a 32-pixel linear light sensor. A single synchronous start pulse, sampled on a rising clock edge, freezes the pixel sample-and-hold stages, begins stepping a one-hot pixel select through the array one pixel per clock, and clears the integration capacitors with a one-clock active-low pulse so that the next exposure accumulates in the background while the frozen values are read. A shutter input pauses integration while it is high.

Pixel 32 is frozen one clock after pixels 1 to 31 and released one clock after them. This staggering lets a complete readout fit in exactly 32 clocks. A start that arrives before the run has finished restarts the selection at pixel 1 and keeps the frozen values. When the clock keeps running with no new start, the select parks on pixel 1 with both hold controls released, so the output tracks that pixel live.

Top module: `lfs_readout_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block resets synchronously. In reset, `pix_sel` selects pixel 1 (bit 0 set), `hold_main` and `hold_last` are 0, `integ_en` is 0, and `intrst_n` is 0. A `start` during reset is ignored.
- R2: A rising edge with `start` high makes `pix_sel` equal to bit 0 (pixel 1) and sets `hold_main` to 1, both from that edge on.
- R3: Without a further start, each later rising edge advances the select by one pixel. Pixel n is bit n-1, and pixel 32 is reached on the 31st edge after the start edge.
- R4: After a start from idle, `hold_last` rises on the edge after the start edge. `hold_main` falls on the edge that selects pixel 32, and `hold_last` falls one edge after that.
- R5: `intrst_n` changes only on falling edges. It is low exactly between the 2nd and 3rd falling edges after the start edge, and high at all other falling edges once reset is released.
- R6: A start while pixels 1 to 31 are selected restarts the select at pixel 1. `hold_main` stays 1, and `hold_last` keeps its value on that edge. R3, R4 and R5 timing then restarts from that edge.
- R7: From the 32nd edge after a start with no new start, `pix_sel` stays on pixel 1 with `hold_main` and `hold_last` both 0, indefinitely.
- R8: `integ_en` equals the inverse of `shutter` as sampled on the previous rising edge.
- R9: Out of reset, `pix_sel` has exactly one bit set at every rising edge.
- R10: A start on the edge that follows pixel 32 begins a normal new run, with `hold_main` returning to 1 and `hold_last` held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock; rising edge samples start and shutter |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| start | input | 1 | Readout and integration start request |
| shutter | input | 1 | High pauses integration |
| pix_sel | output | NUM_PIX | One-hot pixel select to the output multiplexer |
| hold_main | output | 1 | Hold control for pixels 1 to NUM_PIX-1 |
| hold_last | output | 1 | Hold control for the last pixel |
| intrst_n | output | 1 | Active-low integration capacitor clear |
| integ_en | output | 1 | Photodiode-to-capacitor connect enable |

## Verification
A wrong pixel position shows at `pix_sel` on the next rising edge. It also moves the hold release and the clear pulse, so `hold_main`, `hold_last` and `intrst_n` disagree with the position counted from the last start within one clock. A counter that wraps instead of parking brings pixel 2 onto `pix_sel` one edge after the park state should have begun. A hold register that wrongly drops on a restart shows as a 0 on `hold_main` in the cycle right after the restarting edge. Sweeping the restart across every pixel position exposes each of these errors at the first affected edge.

// File: rtl/lfs_seq_pkg.sv
// Package: shared helpers for the line sensor readout sequencer.
// Assumes: pixel count of at least 3 (position 2 must exist before the last).
package lfs_seq_pkg;

    // Width of a position counter that holds 1..n_pix+1.
    function automatic int pos_width(input int n_pix);
        return $clog2(n_pix + 2);
    endfunction

endpackage

// File: rtl/lfs_pix_counter.sv
// Module: pixel position counter.
// Holds 1..NUM_PIX while a pixel is being read; parks at NUM_PIX+1 (idle)
// after the last pixel and never wraps. A start forces position 1.
// Assumes: start is synchronous to clk; reset is synchronous active-low.
module lfs_pix_counter
    import lfs_seq_pkg::*;
#(
    parameter int NUM_PIX = 32,
    localparam int CW = pos_width(NUM_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [CW-1:0] pos
);

    localparam logic [CW-1:0] POS_FIRST = CW'(1);
    localparam logic [CW-1:0] POS_PARK  = CW'(NUM_PIX + 1);

    // Purpose: restart at pixel 1, otherwise step until the park value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= POS_PARK;
        end else if (start) begin
            pos <= POS_FIRST;
        end else if (pos != POS_PARK) begin
            pos <= pos + POS_FIRST;
        end
    end

    p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= POS_FIRST) && (pos <= POS_PARK));

    p_start_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (pos == POS_FIRST));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && pos != POS_PARK) |=> (pos == $past(pos) + POS_FIRST));

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && pos == POS_PARK) |=> (pos == POS_PARK));

endmodule

// File: rtl/lfs_hold_ctrl.sv
// Module: sample-and-hold control for the pixel array.
// hold_main freezes pixels 1..NUM_PIX-1 from the start edge until the last
// pixel is selected; hold_last freezes the last pixel one clock later and
// releases it one clock later. A restart leaves both holds where they are.
// Assumes: pos comes from lfs_pix_counter (1..NUM_PIX, park NUM_PIX+1).
module lfs_hold_ctrl
    import lfs_seq_pkg::*;
#(
    parameter int NUM_PIX = 32,
    localparam int CW = pos_width(NUM_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] pos,
    output logic          hold_main,
    output logic          hold_last
);

    localparam logic [CW-1:0] POS_FIRST = CW'(1);
    localparam logic [CW-1:0] POS_PRELAST = CW'(NUM_PIX - 1);
    localparam logic [CW-1:0] POS_LAST  = CW'(NUM_PIX);
    localparam logic [CW-1:0] POS_PARK  = CW'(NUM_PIX + 1);

    // Purpose: freeze the main group on start, release it as the last pixel is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_main <= 1'b0;
        end else if (start) begin
            hold_main <= 1'b1;
        end else if (pos == POS_PRELAST) begin
            hold_main <= 1'b0;
        end
    end

    // Purpose: freeze the last pixel one clock late and release it one clock late.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_last <= 1'b0;
        end else if (!start) begin
            if (pos == POS_FIRST) begin
                hold_last <= 1'b1;
            end else if (pos == POS_LAST) begin
                hold_last <= 1'b0;
            end
        end
    end

    p_last_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_last) |-> (($past(pos) == POS_FIRST) && hold_main));

    p_main_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_main) |-> (pos == POS_LAST));

    p_restart_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && pos < POS_LAST) |=> (hold_main && $stable(hold_last)));

    p_idle_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == POS_PARK) |-> (!hold_main && !hold_last));

endmodule

// File: rtl/lfs_integ_ctl.sv
// Module: integration control.
// intrst_n is a falling-edge register that goes low for one clock while the
// position counter shows 2, which spans the 2nd to 3rd falling edge after a
// start. integ_en is the registered inverse of the shutter input.
// Assumes: rst_n is synchronous; it is sampled on both clock edges here.
module lfs_integ_ctl
    import lfs_seq_pkg::*;
#(
    parameter int NUM_PIX = 32,
    localparam int CW = pos_width(NUM_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shutter,
    input  logic [CW-1:0] pos,
    output logic          intrst_n,
    output logic          integ_en
);

    localparam logic [CW-1:0] POS_CLEAR = CW'(2);

    // Purpose: clear the integration capacitors during reset and at position 2.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            intrst_n <= 1'b0;
        end else begin
            intrst_n <= (pos != POS_CLEAR);
        end
    end

    // Purpose: connect the photodiodes unless the shutter is closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ_en <= 1'b0;
        end else begin
            integ_en <= !shutter;
        end
    end

    p_clear_one_clk_r5: assert property (@(negedge clk) disable iff (!rst_n)
        !intrst_n |=> intrst_n);

    p_shutter_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (integ_en == !$past(shutter)));

endmodule

// File: rtl/lfs_sel_decode.sv
// Module: one-hot pixel select decoder.
// Position n (1..NUM_PIX) selects bit n-1; the park position selects bit 0
// so the output follows pixel 1 while idle.
// Assumes: pos stays within 1..NUM_PIX+1.
module lfs_sel_decode
    import lfs_seq_pkg::*;
#(
    parameter int NUM_PIX = 32,
    localparam int CW = pos_width(NUM_PIX)
) (
    input  logic [CW-1:0]      pos,
    output logic [NUM_PIX-1:0] pix_sel
);

    localparam logic [CW-1:0] POS_PARK = CW'(NUM_PIX + 1);

    for (genvar gi = 0; gi < NUM_PIX; gi++) begin : g_sel
        if (gi == 0) begin : g_first
            // Purpose: pixel 1 is selected in its slot and while parked.
            assign pix_sel[gi] = (pos == CW'(1)) || (pos == POS_PARK);
        end else begin : g_rest
            // Purpose: every other pixel is selected only in its own slot.
            assign pix_sel[gi] = (pos == CW'(gi + 1));
        end
    end

endmodule

// File: rtl/lfs_readout_seq.sv
// Module: top of the line sensor readout sequencer.
// Ties the position counter, hold control, integration control and select
// decoder together. All outputs are registered or decoded from registers.
// Assumes: start and shutter are synchronous to clk.
module lfs_readout_seq
    import lfs_seq_pkg::*;
#(
    parameter int NUM_PIX = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               shutter,
    output logic [NUM_PIX-1:0] pix_sel,
    output logic               hold_main,
    output logic               hold_last,
    output logic               intrst_n,
    output logic               integ_en
);

    localparam int CW = pos_width(NUM_PIX);

    logic [CW-1:0] pos;

    lfs_pix_counter #(.NUM_PIX(NUM_PIX)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .pos   (pos)
    );

    lfs_hold_ctrl #(.NUM_PIX(NUM_PIX)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pos       (pos),
        .hold_main (hold_main),
        .hold_last (hold_last)
    );

    lfs_integ_ctl #(.NUM_PIX(NUM_PIX)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .shutter  (shutter),
        .pos      (pos),
        .intrst_n (intrst_n),
        .integ_en (integ_en)
    );

    lfs_sel_decode #(.NUM_PIX(NUM_PIX)) u_sel (
        .pos     (pos),
        .pix_sel (pix_sel)
    );

    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pix_sel) == 1);

    p_hold_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_last && !hold_main) |-> pix_sel[NUM_PIX-1]);

endmodule

// File: tb/lfs_readout_seq_test.sv
module lfs_readout_seq_test;

    localparam int NUM_PIX = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               shutter = 1'b0;
    logic [NUM_PIX-1:0] pix_sel;
    logic               hold_main;
    logic               hold_last;
    logic               intrst_n;
    logic               integ_en;

    int total = 0;
    int bad = 0;
    int ek = -1;          // edges since last start, -1 before any start
    bit ehl = 1'b0;       // expected hold_last
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lfs_readout_seq #(.NUM_PIX(NUM_PIX)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .shutter   (shutter),
        .pix_sel   (pix_sel),
        .hold_main (hold_main),
        .hold_last (hold_last),
        .intrst_n  (intrst_n),
        .integ_en  (integ_en)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, update the expected model, check after both edges.
    task automatic cyc(input bit st, input bit sh);
        logic [NUM_PIX-1:0] esel;
        int idx;
        bit ehm;
        start = st;
        shutter = sh;
        @(posedge clk);
        if (st) begin
            ek = 0;              // R6/R10: hold_last keeps its value
        end else begin
            if (ek >= 0 && ek < 100000) ek++;
            ehl = (ek >= 1 && ek <= 31);
        end
        idx = (ek >= 0 && ek <= NUM_PIX - 1) ? ek : 0;
        esel = '0;
        esel[idx] = 1'b1;
        ehm = (ek >= 0 && ek <= NUM_PIX - 2);
        #1;
        chk(pix_sel == esel, (ek == 0) ? "R2 select" : ((ek < 0 || ek >= NUM_PIX) ? "R7 parked select" : "R3 select step"),
            64'(pix_sel), 64'(esel));
        chk($countones(pix_sel) == 1, "R9 one-hot", 64'($countones(pix_sel)), 64'd1);
        chk(hold_main == ehm, st ? "R6 hold_main on start" : "R4 hold_main", 64'(hold_main), 64'(ehm));
        chk(hold_last == ehl, st ? "R10 hold_last kept" : "R4 hold_last", 64'(hold_last), 64'(ehl));
        chk(integ_en == !sh, "R8 integ_en", 64'(integ_en), 64'(!sh));
        @(negedge clk);
        #1;
        chk(intrst_n == !(ek == 1), "R5 intrst_n", 64'(intrst_n), 64'(!(ek == 1)));
    endtask

    initial begin
        // R1: reset state with start held high, which must be ignored
        start = 1'b1;
        for (int i = 0; i < 4; i++) @(posedge clk);
        #1;
        chk(pix_sel == NUM_PIX'(1), "R1 reset select", 64'(pix_sel), 64'd1);
        chk(!hold_main && !hold_last, "R1 reset holds", 64'({hold_main, hold_last}), 64'd0);
        chk(!integ_en, "R1 reset integ_en", 64'(integ_en), 64'd0);
        @(negedge clk);
        #1;
        chk(!intrst_n, "R1 reset intrst_n", 64'(intrst_n), 64'd0);
        rst_n = 1'b1;
        start = 1'b0;

        // R7: idle before any start
        for (int i = 0; i < 5; i++) cyc(1'b0, i[0]);

        // R2 R3 R4 R5 R7: a full run from idle, then park
        cyc(1'b1, 1'b0);
        for (int i = 0; i < 45; i++) cyc(1'b0, (i % 5) == 0);

        // R6 R10: restart at every position 1..32
        for (int j = 1; j <= NUM_PIX; j++) begin
            cyc(1'b1, j[1]);
            for (int i = 0; i < j - 1; i++) cyc(1'b0, (i % 3) == 1);
        end
        cyc(1'b1, 1'b1);
        for (int i = 0; i < 40; i++) cyc(1'b0, (i % 7) < 3);

        // R7: long idle stretch
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule